// File: doc/BRIEF.md
# Scattered-Address Memory Self-Test Engine

This block checks that a memory region is wired and configured correctly by writing a fixed set of 256 words and then reading them back. A single 10-bit index drives both the target address and the data word. The index advances in steps of four. Each data word is a walking-one byte pattern, and half of the words are inverted. The addresses are spread over strides of 16 bytes, 256 bytes, 4 KiB and 64 KiB, so the high address lines are exercised as well as every byte lane of a wide bus.

A run starts with a one-cycle `start` while the block is idle. The block issues every write first and waits until each of them has been acknowledged. It then issues the reads one at a time, in the same index order, and compares each returned word with the regenerated expected value. Every mismatch produces a one-cycle report of the address, the expected word and the observed word. A sticky fail flag and an end-of-run status code summarise the outcome.

The memory side is a plain request port with a `ready` handshake. Writes are completed by a separate acknowledge. Read data returns on `mem_rvalid`. The number of writes in flight is bounded by a parameter.

Top module: `scatter_memtest`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `mem_req` and `mis_valid` are 0 and `status` is 0x00. No request is raised while idle.
- R2: A `start` seen while idle begins a run, and `busy` is 1 from the next cycle. A `start` seen while busy has no effect: the run continues with its original base address, and `fail` is not cleared.
- R3: The write pass issues exactly 256 writes for index values 0, 4, 8, ... 0x3FC. For index i, let k = i[9:8]+1 and j = i[7:4]. The byte address is base + (i[3:0] OR (j << 4k)). Every request address is word aligned.
- R4: The write data for index i is 0x01010101 shifted left by j[2:0] within 32 bits. The word is bitwise inverted when j[3] is 1.
- R5: Bits [6:0] of `base_addr` are ignored, so the effective base is aligned to 128 bytes.
- R6: No read request is raised until every accepted write has been acknowledged on `mem_wack`.
- R7: The verify pass reads the same 256 addresses in the same order. A new read request is raised only after the previous read's `mem_rvalid`, and exactly 256 reads complete.
- R8: A returned word that differs from the expected word causes `mis_valid` to be high for one cycle, on the cycle after `mem_rvalid`. At the same time `mis_addr`, `mis_exp` and `mis_obs` carry the full address, the expected word and the returned word, and `fail` is 1.
- R9: `fail` is set by the first mismatch and stays set until the next accepted `start`, which clears it.
- R10: `done` is a one-cycle pulse on the cycle after the last read returns, and `busy` is 0 in that cycle. `status` then reads 0xEA if the run had any mismatch and 0x00 otherwise.
- R11: While `mem_req` is high and `mem_ready` is low, the request, its address and its direction stay unchanged in the next cycle.
- R12: At most 2^OUTST_W-1 writes are outstanding. No write request is raised while that many await acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; used only while idle |
| base_addr | input | ADDR_W | Region base byte address; bits [6:0] ignored |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write (1) or a read (0) |
| mem_addr | output | ADDR_W | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_wack | input | 1 | One earlier write has completed |
| mem_rvalid | input | 1 | Read data valid for the pending read |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag for the current or last run |
| status | output | 8 | Result code of the last run: 0xEA fail, 0x00 pass |
| mis_valid | output | 1 | Mismatch report valid |
| mis_addr | output | ADDR_W | Address of the failing read |
| mis_exp | output | 32 | Expected word |
| mis_obs | output | 32 | Word read back |

## Verification
The bench builds the block with ADDR_W = 32 and OUTST_W = 2, so only three writes may be in flight. With a write acknowledge latency of seven cycles, the cap is reached again and again during the write pass. This exercises both the throttle and a long barrier drain before the first read. The bench also uses a stalling `ready` pattern, an unaligned base, a `start` pulse in the middle of a run, and corrupted words on the sixth read and on the last read, which bring the hold, masking, ignore and last-read failure paths within reach. A third run follows the failing run and shows that the sticky flag is cleared.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

    localparam int IDX_W      = 10;
    localparam int WORD_W     = 32;
    localparam int IDX_STEP   = 4;
    localparam int ALIGN_BITS = 7;
    localparam int SPREAD_N   = 4;
    localparam int NIB_W      = 4;
    localparam int OFF_W      = NIB_W + NIB_W * SPREAD_N;

    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'((1 << IDX_W) - IDX_STEP);
    localparam logic [WORD_W-1:0] SEED_WORD = 32'h0101_0101;
    localparam logic [7:0]        CODE_FAIL = 8'hEA;
    localparam logic [7:0]        CODE_PASS = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_DRAIN,
        ST_RD_REQ,
        ST_RD_WAIT
    } phase_e;

endpackage

// File: rtl/mt_pattern_gen.sv
module mt_pattern_gen
    import memtest_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WORD_W-1:0] data_o
);

    logic [NIB_W-1:0] low_nib;
    logic [NIB_W-1:0] sel_j;
    logic [1:0]       spread_sel;
    logic [OFF_W-1:0] spread [SPREAD_N];
    logic [OFF_W-1:0] offset;
    logic [WORD_W-1:0] walk;

    assign low_nib    = idx_i[NIB_W-1:0];
    assign sel_j      = idx_i[2*NIB_W-1:NIB_W];
    assign spread_sel = idx_i[IDX_W-1:IDX_W-2];

    // one candidate placement of j per stride: 16 B, 256 B, 4 KiB, 64 KiB
    generate
        for (genvar g = 0; g < SPREAD_N; g++) begin : g_spread
            assign spread[g] = OFF_W'(sel_j) << (NIB_W * (g + 1));
        end
    endgenerate

    assign offset = spread[spread_sel] | OFF_W'(low_nib);
    assign addr_o = base_i + ADDR_W'(offset);

    assign walk   = SEED_WORD << sel_j[2:0];
    assign data_o = sel_j[3] ? ~walk : walk;

endmodule

// File: rtl/mt_wr_tracker.sv
module mt_wr_tracker #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_i,
    input  logic retire_i,
    output logic empty_o,
    output logic full_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (issue_i && !retire_i) begin
            cnt_d = cnt_q + 1'b1;
        end else if (!issue_i && retire_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CNT_MAX);

endmodule

// File: rtl/mt_read_cmp.sv
module mt_read_cmp
    import memtest_pkg::*;
(
    input  logic              valid_i,
    input  logic [WORD_W-1:0] obs_i,
    input  logic [WORD_W-1:0] exp_i,
    output logic              miss_o
);

    assign miss_o = valid_i && (obs_i != exp_i);

endmodule

// File: rtl/scatter_memtest.sv
module scatter_memtest
    import memtest_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OUTST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_wack,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [7:0]        status,
    output logic              mis_valid,
    output logic [ADDR_W-1:0] mis_addr,
    output logic [WORD_W-1:0] mis_exp,
    output logic [WORD_W-1:0] mis_obs
);

    typedef struct packed {
        phase_e            phase;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] base;
        logic              fail;
        logic              done;
        logic [7:0]        status;
        logic              mis_valid;
        logic [ADDR_W-1:0] mis_addr;
        logic [WORD_W-1:0] mis_exp;
        logic [WORD_W-1:0] mis_obs;
    } regs_t;

    regs_t r_d, r_q;

    logic [ADDR_W-1:0] gen_addr;
    logic [WORD_W-1:0] gen_data;
    logic              wr_empty, wr_full, wr_fire;
    logic              rd_miss, at_last;

    mt_pattern_gen #(.ADDR_W(ADDR_W)) u_pattern (
        .base_i (r_q.base),
        .idx_i  (r_q.idx),
        .addr_o (gen_addr),
        .data_o (gen_data)
    );

    mt_wr_tracker #(.CNT_W(OUTST_W)) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_i  (wr_fire),
        .retire_i (mem_wack),
        .empty_o  (wr_empty),
        .full_o   (wr_full)
    );

    mt_read_cmp u_cmp (
        .valid_i (mem_rvalid && (r_q.phase == ST_RD_WAIT)),
        .obs_i   (mem_rdata),
        .exp_i   (gen_data),
        .miss_o  (rd_miss)
    );

    assign at_last   = (r_q.idx == IDX_LAST);
    assign mem_we    = (r_q.phase == ST_WRITE);
    assign mem_req   = ((r_q.phase == ST_WRITE) && !wr_full) || (r_q.phase == ST_RD_REQ);
    assign mem_addr  = gen_addr;
    assign mem_wdata = gen_data;
    assign wr_fire   = mem_req && mem_we && mem_ready;

    always_comb begin
        r_d           = r_q;
        r_d.done      = 1'b0;
        r_d.mis_valid = 1'b0;
        unique case (r_q.phase)
            ST_IDLE: begin
                if (start) begin
                    r_d.phase = ST_WRITE;
                    r_d.idx   = '0;
                    r_d.base  = {base_addr[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
                    r_d.fail  = 1'b0;
                end
            end
            ST_WRITE: begin
                if (wr_fire) begin
                    if (at_last) begin
                        r_d.phase = ST_DRAIN;
                    end else begin
                        r_d.idx = r_q.idx + IDX_W'(IDX_STEP);
                    end
                end
            end
            ST_DRAIN: begin
                if (wr_empty) begin
                    r_d.phase = ST_RD_REQ;
                    r_d.idx   = '0;
                end
            end
            ST_RD_REQ: begin
                if (mem_ready) begin
                    r_d.phase = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                if (mem_rvalid) begin
                    if (rd_miss) begin
                        r_d.fail      = 1'b1;
                        r_d.mis_valid = 1'b1;
                        r_d.mis_addr  = gen_addr;
                        r_d.mis_exp   = gen_data;
                        r_d.mis_obs   = mem_rdata;
                    end
                    if (at_last) begin
                        r_d.phase  = ST_IDLE;
                        r_d.done   = 1'b1;
                        r_d.status = (r_q.fail || rd_miss) ? CODE_FAIL : CODE_PASS;
                    end else begin
                        r_d.phase = ST_RD_REQ;
                        r_d.idx   = r_q.idx + IDX_W'(IDX_STEP);
                    end
                end
            end
            default: r_d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.phase != ST_IDLE);
    assign done      = r_q.done;
    assign fail      = r_q.fail;
    assign status    = r_q.status;
    assign mis_valid = r_q.mis_valid;
    assign mis_addr  = r_q.mis_addr;
    assign mis_exp   = r_q.mis_exp;
    assign mis_obs   = r_q.mis_obs;

endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
    parameter int ADDR_W  = 32,
    parameter int OUTST_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [7:0]        status,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic              mem_wack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mis_valid
);

    localparam logic [31:0] PEND_MAX = 32'((1 << OUTST_W) - 1);

    logic [31:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_q + 32'(mem_req && mem_we && mem_ready) - 32'(mem_wack && pend_q != 0);
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_req); // R1
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> mem_addr[1:0] == 2'b00); // R3
    AST_READ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_we) |-> pend_q == 0); // R6
    AST_MIS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) mis_valid |-> fail); // R8
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (fail && !(start && !busy)) |=> fail); // R9
    AST_FAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> !fail); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R10
    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n) done |-> status == (fail ? 8'hEA : 8'h00)); // R10
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11
    AST_OUTST_CAP: assert property (@(posedge clk) disable iff (!rst_n) pend_q <= PEND_MAX); // R12

endmodule

bind scatter_memtest mt_checker #(.ADDR_W(ADDR_W), .OUTST_W(OUTST_W)) u_mt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .status    (status),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_wack  (mem_wack),
    .mem_addr  (mem_addr),
    .mis_valid (mis_valid)
);

// File: tb/test_scatter_memtest.sv
module test_scatter_memtest;

    localparam int AW   = 32;
    localparam int OW   = 2;
    localparam int OMAX = 3;
    localparam int NACC = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_ready = 1'b0, mem_wack = 1'b0, mem_rvalid = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          busy, done, fail, mis_valid;
    logic [7:0]    status;
    logic [AW-1:0] mis_addr;
    logic [31:0]   mis_exp, mis_obs;

    always #4 clk = ~clk;

    scatter_memtest #(.ADDR_W(AW), .OUTST_W(OW)) i_scatter_memtest (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_wack(mem_wack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fail(fail), .status(status),
        .mis_valid(mis_valid), .mis_addr(mis_addr), .mis_exp(mis_exp), .mis_obs(mis_obs)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_off(input int idx);
        int k = idx / 256 + 1;
        int j = (idx / 16) % 16;
        return 32'(idx % 16) | (32'(j) << (4 * k));
    endfunction

    function automatic logic [31:0] ref_word(input int idx);
        int j = (idx / 16) % 16;
        logic [31:0] w = 32'h0101_0101 << (j % 8);
        return (j >= 8) ? ~w : w;
    endfunction

    // memory and response model
    logic [31:0] mem [logic [31:0]];
    int          wq[$];
    int          rq_due[$];
    logic [31:0] rq_obs[$], rq_exp[$], rq_addr[$];

    // knobs
    int rdy_mode = 0, wlat = 1, rlat = 1, bad_a = -1, bad_b = -1;
    bit start_now = 0;
    logic [31:0] start_base = '0;

    // reference state
    int  cyc = 0, wr_n = 0, rd_n = 0, rd_ret = 0, out_n = 0, mis_n = 0;
    bit  model_busy = 0, model_fail = 0, exp_done_now = 0, exp_mis_now = 0, done_seen = 0;
    bit  rd_pending = 0, prev_stall = 0, prev_we = 0;
    logic [31:0] prev_addr = '0, eff_base = '0, exp_ma = '0, exp_me = '0, exp_mo = '0;
    logic [7:0]  exp_status = 8'h00;

    task automatic tick();
        int out_snap;
        bit rdy;
        @(negedge clk);
        cyc++;
        out_snap = out_n;
        // observation
        chk(busy === model_busy, "R2", "busy", 32'(busy), 32'(model_busy));
        chk(fail === model_fail, "R9", "fail", 32'(fail), 32'(model_fail));
        chk(done === exp_done_now, "R10", "done", 32'(done), 32'(exp_done_now));
        if (exp_done_now) begin
            done_seen = 1;
            chk(status === exp_status, "R10", "status", 32'(status), 32'(exp_status));
        end
        chk(mis_valid === exp_mis_now, "R8", "mis_valid", 32'(mis_valid), 32'(exp_mis_now));
        if (exp_mis_now) begin
            mis_n++;
            chk(mis_addr === exp_ma, "R8", "mis_addr", mis_addr, exp_ma);
            chk(mis_exp === exp_me, "R8", "mis_exp", mis_exp, exp_me);
            chk(mis_obs === exp_mo, "R8", "mis_obs", mis_obs, exp_mo);
        end
        if (prev_stall) begin
            chk(mem_req === 1'b1, "R11", "req held", 32'(mem_req), 32'd1);
            chk(mem_addr === prev_addr && mem_we === prev_we, "R11", "addr held", mem_addr, prev_addr);
        end
        if (rd_pending) chk(mem_req === 1'b0, "R7", "read while pending", 32'(mem_req), 32'd0);
        if (!model_busy) chk(mem_req === 1'b0, "R1", "idle request", 32'(mem_req), 32'd0);
        exp_done_now = 0;
        exp_mis_now  = 0;
        // write acknowledge
        mem_wack = 1'b0;
        if (wq.size() > 0 && wq[0] <= cyc) begin
            void'(wq.pop_front());
            mem_wack = 1'b1;
            out_n--;
        end
        // read return
        mem_rvalid = 1'b0;
        if (rq_due.size() > 0 && rq_due[0] <= cyc) begin
            logic [31:0] o, e, a;
            void'(rq_due.pop_front());
            o = rq_obs.pop_front(); e = rq_exp.pop_front(); a = rq_addr.pop_front();
            mem_rvalid = 1'b1;
            mem_rdata  = o;
            rd_pending = 0;
            rd_ret++;
            if (o != e) begin
                exp_mis_now = 1; exp_ma = a; exp_me = e; exp_mo = o;
                model_fail = 1;
            end
            if (rd_ret == NACC) begin
                exp_done_now = 1;
                model_busy   = 0;
                exp_status   = model_fail ? 8'hEA : 8'h00;
            end
        end
        // request handshake
        rdy = (rdy_mode == 0) || (cyc % 3 != 0);
        mem_ready = rdy;
        if (mem_req === 1'b1 && rdy) begin
            if (mem_we) begin
                chk(wr_n < NACC, "R3", "write count", 32'(wr_n), 32'(NACC - 1));
                chk(mem_addr === eff_base + ref_off(4 * wr_n), "R3", "write addr", mem_addr, eff_base + ref_off(4 * wr_n));
                chk(mem_wdata === ref_word(4 * wr_n), "R4", "write data", mem_wdata, ref_word(4 * wr_n));
                chk(out_snap < OMAX, "R12", "outstanding cap", 32'(out_snap), 32'(OMAX - 1));
                mem[mem_addr] = mem_wdata;
                wr_n++;
                out_n++;
                wq.push_back(cyc + wlat);
            end else begin
                logic [31:0] ea, ev, ob;
                ea = eff_base + ref_off(4 * rd_n);
                ev = ref_word(4 * rd_n);
                chk(out_snap == 0, "R6", "read before drain", 32'(out_snap), 32'd0);
                chk(wr_n == NACC, "R6", "writes before read", 32'(wr_n), 32'(NACC));
                chk(mem_addr === ea, "R7", "read addr", mem_addr, ea);
                ob = mem.exists(mem_addr) ? mem[mem_addr] : 32'hDEAD_BEEF;
                if (rd_n == bad_a || rd_n == bad_b) ob = ob ^ 32'h0000_0100;
                rq_due.push_back(cyc + rlat); rq_obs.push_back(ob);
                rq_exp.push_back(ev); rq_addr.push_back(mem_addr);
                rd_n++;
                rd_pending = 1;
            end
        end
        prev_stall = (mem_req === 1'b1) && !rdy;
        prev_addr  = mem_addr;
        prev_we    = mem_we;
        // start
        start     = start_now;
        base_addr = start_base;
        if (start_now && !model_busy) begin
            model_busy = 1; model_fail = 0;
            eff_base = start_base & 32'hFFFF_FF80;
            wr_n = 0; rd_n = 0; rd_ret = 0; mis_n = 0; done_seen = 0;
        end
        start_now = 0;
    endtask

    task automatic do_run(input logic [31:0] b, input int mid_tick, input logic [31:0] mid_base,
                          input int exp_mis, input string tag);
        int n = 0;
        start_now = 1; start_base = b;
        tick();
        while (!done_seen && n < 20000) begin
            if (n == mid_tick) begin start_now = 1; start_base = mid_base; end
            tick();
            n++;
        end
        if (!done_seen) chk(0, tag, "watchdog expired", 32'(n), 32'd20000);
        chk(wr_n == NACC, "R3", "writes per run", 32'(wr_n), 32'(NACC));
        chk(rd_ret == NACC, "R7", "reads per run", 32'(rd_ret), 32'(NACC));
        chk(mis_n == exp_mis, "R8", "mismatch reports", 32'(mis_n), 32'(exp_mis));
        repeat (3) tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0, "R1", "busy", 32'(busy), 32'd0);
        chk(done === 1'b0, "R1", "done", 32'(done), 32'd0);
        chk(fail === 1'b0, "R1", "fail", 32'(fail), 32'd0);
        chk(mem_req === 1'b0, "R1", "mem_req", 32'(mem_req), 32'd0);
        chk(mis_valid === 1'b0, "R1", "mis_valid", 32'(mis_valid), 32'd0);
        chk(status === 8'h00, "R1", "status", 32'(status), 32'd0);
        rst_n = 1'b1;
        repeat (2) tick();
        // run A: clean, no stalls, short latencies
        rdy_mode = 0; wlat = 1; rlat = 1; bad_a = -1; bad_b = -1;
        do_run(32'h0001_0000, -1, '0, 0, "R10");
        // run B: unaligned base (R5), stalls (R11), deep cap (R12), mid-run start (R2), two faults
        rdy_mode = 1; wlat = 7; rlat = 3; bad_a = 5; bad_b = NACC - 1;
        do_run(32'h2000_0055, 100, 32'h4000_0000, 2, "R5");
        // run C: fail cleared by new start (R9), passing status
        rdy_mode = 1; wlat = 2; rlat = 2; bad_a = -1; bad_b = -1;
        do_run(32'h0300_0080, -1, '0, 0, "R9");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule